// File: doc/BRIEF.md
# Windowed Address Translation Unit

This block holds two banks of address windows, one for traffic coming into the chip and one for traffic going out. Software programs the windows through a small register space. A select register names the window that the other per-window registers refer to. For each window it holds a 64-bit start address, a 32-bit end address, a 64-bit destination and a type word. A control word carries the enable.

Writing the base, end, destination or type registers only loads staging registers. The window's live decode changes only when its control word is written. A live window of memory type moves a matching address to the destination: the result is the address, minus the start, plus the destination. A live window of configuration type instead returns a bus number, a device/function number and a byte offset into configuration space.

A lookup port takes an address and a direction flag. One clock later it returns whether a window matched, which kind matched, and the translated fields. At reset, inbound window 0 is live and covers the low 4 GiB with no offset, so inbound traffic passes through unchanged.

Top module: `atu_viewport_top`

## Requirements
- R1: The select register at offset 0x900 reads back the last value written to it. Its bits [3:0] pick the window index and its bit 31 picks the bank (1 inbound, 0 outbound). Every per-window register access reaches only the window it selects.
- R2: Each window's registers read back the last value written: type at 0x904, control at 0x908, start low/high at 0x90C/0x910, end at 0x914, destination low/high at 0x918/0x91C. The two halves of a 64-bit value are written independently.
- R3: Writes to start, end, destination or type do not change lookup results until that window's control register is written. A control write copies the staged values into the live decode.
- R4: Control bit 31 enables a window. A window whose live enable is 0 never matches.
- R5: A live window matches an address A when start <= A <= end, where end is zero-extended to 64 bits. When no window matches, the hit, type, address, bus, device/function and offset outputs are all 0.
- R6: A matching window whose live type word is 0 (memory) returns hit=1, cfg=0, address = A - start + destination modulo 2^64, and bus, device/function and offset equal to 0.
- R7: A matching window whose live type word is non-zero (configuration) returns hit=1, cfg=1, bus = destination[31:24], device/function = destination[23:16], offset = A[11:0], and address 0. Switching a window's type and then writing its control word removes its previous behaviour completely.
- R8: The lookup results and lk_valid_o are registered. They appear on the clock edge after the one that samples lk_valid_i=1, and they hold while no request is made.
- R9: When several live windows of the selected bank match, the lowest index wins.
- R10: After reset every window has start 0, destination 0, end 0xFFFFFFFF, type 0 and control 0. The exception is inbound window 0, whose control reads 0x80000000 and which is live, so inbound addresses below 2^32 translate to themselves. The select register resets to 0.
- R11: lk_inbound_i=1 searches only the inbound bank and 0 only the outbound bank.
- R12: A read of any offset other than those in R1 and R2 returns 0. A write to such an offset changes no register and no lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from reg_addr_i) |
| lk_valid_i | input | 1 | Lookup request |
| lk_inbound_i | input | 1 | Lookup bank: 1 inbound, 0 outbound |
| lk_addr_i | input | 64 | Lookup address |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | A window matched |
| lk_cfg_o | output | 1 | The matched window is of configuration type |
| lk_addr_o | output | 64 | Translated address (memory type) |
| lk_bus_o | output | 8 | Bus number (configuration type) |
| lk_devfn_o | output | 8 | Device/function number (configuration type) |
| lk_off_o | output | 12 | Configuration-space offset (configuration type) |

## Verification
The assertions assume that reg_we_i, reg_addr_i and lk_valid_i are known and stable around each rising edge. They also assume that a register write and a lookup aimed at the same window in the same cycle see the decode from before that write. The stimulus drives all inputs on the falling edge and keeps writes and lookups in separate cycles. Random window settings keep start and end in a small range so that overlaps, boundary hits and misses all occur. An occasional non-zero upper start word is added to produce windows that can never match.

// File: rtl/atu_pkg.sv
`timescale 1ns/1ps
package atu_pkg;
  localparam logic [11:0] OFS_VSEL    = 12'h900;
  localparam logic [11:0] OFS_TYPE    = 12'h904;
  localparam logic [11:0] OFS_CTRL    = 12'h908;
  localparam logic [11:0] OFS_BASE_LO = 12'h90C;
  localparam logic [11:0] OFS_BASE_HI = 12'h910;
  localparam logic [11:0] OFS_LIMIT   = 12'h914;
  localparam logic [11:0] OFS_TGT_LO  = 12'h918;
  localparam logic [11:0] OFS_TGT_HI  = 12'h91C;
  localparam int          EN_BIT      = 31;

  typedef enum logic [2:0] {
    F_NONE, F_TYPE, F_CTRL, F_BASE_LO, F_BASE_HI, F_LIMIT, F_TGT_LO, F_TGT_HI
  } win_field_e;

  typedef struct packed {
    logic [63:0] base;
    logic [31:0] limit;
    logic [63:0] tgt;
    logic [31:0] kind;
    logic [31:0] ctrl;
  } win_cfg_t;
endpackage

// File: rtl/atu_window.sv
`timescale 1ns/1ps
module atu_window
  import atu_pkg::*;
#(
  parameter bit RST_EN = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  win_field_e  fld_i,
  input  logic [31:0] wdata_i,
  input  logic [63:0] lk_addr_i,
  output win_cfg_t    cfg_o,
  output logic        hit_o,
  output logic        is_cfg_o,
  output logic [63:0] xlat_o,
  output logic [15:0] bdf_o
);
  win_cfg_t    shd_q;
  logic [63:0] act_base_q, act_tgt_q;
  logic [31:0] act_limit_q;
  logic        act_cfg_q, act_en_q;
  logic        load;

  assign load = wr_i && (fld_i == F_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q.base  <= '0;
      shd_q.limit <= '1;
      shd_q.tgt   <= '0;
      shd_q.kind  <= '0;
      shd_q.ctrl  <= RST_EN ? 32'h8000_0000 : 32'h0;
    end else if (wr_i) begin
      unique case (fld_i)
        F_TYPE:    shd_q.kind        <= wdata_i;
        F_CTRL:    shd_q.ctrl        <= wdata_i;
        F_BASE_LO: shd_q.base[31:0]  <= wdata_i;
        F_BASE_HI: shd_q.base[63:32] <= wdata_i;
        F_LIMIT:   shd_q.limit       <= wdata_i;
        F_TGT_LO:  shd_q.tgt[31:0]   <= wdata_i;
        F_TGT_HI:  shd_q.tgt[63:32]  <= wdata_i;
        default:   ;
      endcase
    end
  end

  // live decode is refreshed only by a control write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_base_q  <= '0;
      act_limit_q <= '1;
      act_tgt_q   <= '0;
      act_cfg_q   <= 1'b0;
      act_en_q    <= RST_EN;
    end else if (load) begin
      act_base_q  <= shd_q.base;
      act_limit_q <= shd_q.limit;
      act_tgt_q   <= shd_q.tgt;
      act_cfg_q   <= |shd_q.kind;
      act_en_q    <= wdata_i[EN_BIT];
    end
  end

  assign cfg_o    = shd_q;
  assign hit_o    = act_en_q && (lk_addr_i >= act_base_q) && (lk_addr_i <= {32'h0, act_limit_q});
  assign is_cfg_o = act_cfg_q;
  assign xlat_o   = lk_addr_i - act_base_q + act_tgt_q;
  assign bdf_o    = act_tgt_q[31:16];

  p_live_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable({act_base_q, act_limit_q, act_tgt_q, act_cfg_q, act_en_q}));

  p_dis_nohit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !wdata_i[EN_BIT]) |=> !hit_o);
endmodule

// File: rtl/atu_lookup.sv
`timescale 1ns/1ps
module atu_lookup #(
  parameter int NUM_WIN = 16,
  parameter int OFS_W   = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lk_valid_i,
  input  logic [OFS_W-1:0]         lk_ofs_i,
  input  logic [NUM_WIN-1:0]       hit_i,
  input  logic [NUM_WIN-1:0]       cfg_i,
  input  logic [NUM_WIN-1:0][63:0] xlat_i,
  input  logic [NUM_WIN-1:0][15:0] bdf_i,
  output logic                     lk_valid_o,
  output logic                     lk_hit_o,
  output logic                     lk_cfg_o,
  output logic [63:0]              lk_addr_o,
  output logic [7:0]               lk_bus_o,
  output logic [7:0]               lk_devfn_o,
  output logic [OFS_W-1:0]         lk_off_o
);
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [IDX_W-1:0] win_idx;
  logic             any_hit, sel_cfg;

  always_comb begin
    win_idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_i[i]) win_idx = IDX_W'(i);
    end
  end

  assign any_hit = |hit_i;
  assign sel_cfg = any_hit && cfg_i[win_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o <= 1'b0;
      lk_hit_o   <= 1'b0;
      lk_cfg_o   <= 1'b0;
      lk_addr_o  <= '0;
      lk_bus_o   <= '0;
      lk_devfn_o <= '0;
      lk_off_o   <= '0;
    end else begin
      lk_valid_o <= lk_valid_i;
      if (lk_valid_i) begin
        lk_hit_o   <= any_hit;
        lk_cfg_o   <= sel_cfg;
        lk_addr_o  <= (any_hit && !sel_cfg) ? xlat_i[win_idx] : '0;
        lk_bus_o   <= sel_cfg ? bdf_i[win_idx][15:8] : '0;
        lk_devfn_o <= sel_cfg ? bdf_i[win_idx][7:0] : '0;
        lk_off_o   <= sel_cfg ? lk_ofs_i : '0;
      end
    end
  end

  p_lowest_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_hit |-> (hit_i[win_idx] &&
                 ((hit_i & ((NUM_WIN'(1) << win_idx) - NUM_WIN'(1))) == '0)));

  p_one_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_valid_o);

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> $stable({lk_hit_o, lk_cfg_o, lk_addr_o, lk_bus_o, lk_devfn_o, lk_off_o}));

  p_miss_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_o && !lk_hit_o) |-> (!lk_cfg_o && lk_addr_o == '0 && lk_bus_o == '0 &&
                                   lk_devfn_o == '0 && lk_off_o == '0));

  p_cfg_zero_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_cfg_o |-> (lk_hit_o && lk_addr_o == '0));
endmodule

// File: rtl/atu_viewport_top.sv
`timescale 1ns/1ps
module atu_viewport_top
  import atu_pkg::*;
#(
  parameter  int NUM_WIN   = 16,
  parameter  int CFG_BYTES = 4096,
  localparam int OFS_W     = $clog2(CFG_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [11:0]       reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              lk_valid_i,
  input  logic              lk_inbound_i,
  input  logic [63:0]       lk_addr_i,
  output logic              lk_valid_o,
  output logic              lk_hit_o,
  output logic              lk_cfg_o,
  output logic [63:0]       lk_addr_o,
  output logic [7:0]        lk_bus_o,
  output logic [7:0]        lk_devfn_o,
  output logic [OFS_W-1:0]  lk_off_o
);
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int TOT   = 2 * NUM_WIN;

  logic [31:0]            vsel_q;
  logic [IDX_W:0]         sel_flat;
  win_field_e             fld;
  win_cfg_t               cfgs [TOT];
  win_cfg_t               cur;
  logic [TOT-1:0]         hit_all, cfg_all;
  logic [TOT-1:0][63:0]   xlat_all;
  logic [TOT-1:0][15:0]   bdf_all;

  function automatic win_field_e decode_fld(input logic [11:0] a);
    unique case (a)
      OFS_TYPE:    return F_TYPE;
      OFS_CTRL:    return F_CTRL;
      OFS_BASE_LO: return F_BASE_LO;
      OFS_BASE_HI: return F_BASE_HI;
      OFS_LIMIT:   return F_LIMIT;
      OFS_TGT_LO:  return F_TGT_LO;
      OFS_TGT_HI:  return F_TGT_HI;
      default:     return F_NONE;
    endcase
  endfunction

  assign fld      = decode_fld(reg_addr_i);
  assign sel_flat = {vsel_q[31], vsel_q[IDX_W-1:0]};  // bank * NUM_WIN + index

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vsel_q <= '0;
    else if (reg_we_i && reg_addr_i == OFS_VSEL) vsel_q <= reg_wdata_i;
  end

  for (genvar k = 0; k < TOT; k++) begin : g_win
    atu_window #(.RST_EN(k == NUM_WIN)) u_win (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (reg_we_i && fld != F_NONE && sel_flat == (IDX_W+1)'(k)),
      .fld_i     (fld),
      .wdata_i   (reg_wdata_i),
      .lk_addr_i (lk_addr_i),
      .cfg_o     (cfgs[k]),
      .hit_o     (hit_all[k]),
      .is_cfg_o  (cfg_all[k]),
      .xlat_o    (xlat_all[k]),
      .bdf_o     (bdf_all[k])
    );
  end

  always_comb begin
    cur = cfgs[sel_flat];
    if (reg_addr_i == OFS_VSEL) reg_rdata_o = vsel_q;
    else begin
      unique case (fld)
        F_TYPE:    reg_rdata_o = cur.kind;
        F_CTRL:    reg_rdata_o = cur.ctrl;
        F_BASE_LO: reg_rdata_o = cur.base[31:0];
        F_BASE_HI: reg_rdata_o = cur.base[63:32];
        F_LIMIT:   reg_rdata_o = cur.limit;
        F_TGT_LO:  reg_rdata_o = cur.tgt[31:0];
        F_TGT_HI:  reg_rdata_o = cur.tgt[63:32];
        default:   reg_rdata_o = '0;
      endcase
    end
  end

  atu_lookup #(.NUM_WIN(NUM_WIN), .OFS_W(OFS_W)) u_lookup (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_valid_i (lk_valid_i),
    .lk_ofs_i   (lk_addr_i[OFS_W-1:0]),
    .hit_i      (lk_inbound_i ? hit_all[TOT-1:NUM_WIN]  : hit_all[NUM_WIN-1:0]),
    .cfg_i      (lk_inbound_i ? cfg_all[TOT-1:NUM_WIN]  : cfg_all[NUM_WIN-1:0]),
    .xlat_i     (lk_inbound_i ? xlat_all[TOT-1:NUM_WIN] : xlat_all[NUM_WIN-1:0]),
    .bdf_i      (lk_inbound_i ? bdf_all[TOT-1:NUM_WIN]  : bdf_all[NUM_WIN-1:0]),
    .lk_valid_o (lk_valid_o),
    .lk_hit_o   (lk_hit_o),
    .lk_cfg_o   (lk_cfg_o),
    .lk_addr_o  (lk_addr_o),
    .lk_bus_o   (lk_bus_o),
    .lk_devfn_o (lk_devfn_o),
    .lk_off_o   (lk_off_o)
  );

  p_vsel_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == OFS_VSEL) |=> $stable(vsel_q));
endmodule

// File: tb/atu_viewport_top_tb.sv
`timescale 1ns/1ps
module atu_viewport_top_tb;
  localparam int NW = 16;
  localparam int TOT = 2 * NW;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0, lv = 1'b0, lin = 1'b0;
  logic [11:0] ra = '0;
  logic [31:0] wd = '0;
  logic [63:0] la = '0;
  logic [31:0] rd;
  logic        vo, ho, co;
  logic [63:0] ao;
  logic [7:0]  bo, dfo;
  logic [11:0] oo;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic [31:0] m_vsel;
  logic [63:0] m_base [TOT];
  logic [31:0] m_lim  [TOT];
  logic [63:0] m_tgt  [TOT];
  logic [31:0] m_kind [TOT];
  logic [31:0] m_ctrl [TOT];
  logic [63:0] a_base [TOT];
  logic [31:0] a_lim  [TOT];
  logic [63:0] a_tgt  [TOT];
  logic        a_cfg  [TOT];
  logic        a_en   [TOT];

  always #2.5 clk = ~clk;

  atu_viewport_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(ra), .reg_wdata_i(wd),
    .reg_rdata_o(rd), .lk_valid_i(lv), .lk_inbound_i(lin), .lk_addr_i(la),
    .lk_valid_o(vo), .lk_hit_o(ho), .lk_cfg_o(co), .lk_addr_o(ao), .lk_bus_o(bo),
    .lk_devfn_o(dfo), .lk_off_o(oo)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_vsel = '0;
    for (int k = 0; k < TOT; k++) begin
      m_base[k] = '0; m_lim[k] = 32'hFFFF_FFFF; m_tgt[k] = '0; m_kind[k] = '0;
      m_ctrl[k] = (k == NW) ? 32'h8000_0000 : 32'h0;
      a_base[k] = '0; a_lim[k] = 32'hFFFF_FFFF; a_tgt[k] = '0; a_cfg[k] = 1'b0;
      a_en[k] = (k == NW);
    end
  endtask

  function automatic int cur_win();
    return (m_vsel[31] ? NW : 0) + int'(m_vsel[3:0]);
  endfunction

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    int w;
    @(negedge clk);
    we = 1'b1; ra = a; wd = d;
    @(negedge clk);
    we = 1'b0;
    w = cur_win();
    case (a)
      12'h900: m_vsel = d;
      12'h904: m_kind[w] = d;
      12'h908: begin
        m_ctrl[w] = d;
        a_base[w] = m_base[w]; a_lim[w] = m_lim[w]; a_tgt[w] = m_tgt[w];
        a_cfg[w] = (m_kind[w] != 0); a_en[w] = d[31];
      end
      12'h90C: m_base[w][31:0] = d;
      12'h910: m_base[w][63:32] = d;
      12'h914: m_lim[w] = d;
      12'h918: m_tgt[w][31:0] = d;
      12'h91C: m_tgt[w][63:32] = d;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    int w = cur_win();
    case (a)
      12'h900: return m_vsel;
      12'h904: return m_kind[w];
      12'h908: return m_ctrl[w];
      12'h90C: return m_base[w][31:0];
      12'h910: return m_base[w][63:32];
      12'h914: return m_lim[w];
      12'h918: return m_tgt[w][31:0];
      12'h91C: return m_tgt[w][63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic reg_rd_chk(input string tag, input logic [11:0] a);
    @(negedge clk);
    ra = a;
    #1;
    chk(tag, {32'h0, rd}, {32'h0, exp_rd(a)});
  endtask

  task automatic look(input string tag, input logic dir, input logic [63:0] addr);
    logic eh, ec;
    logic [63:0] ea;
    logic [7:0] eb, ed;
    logic [11:0] eo;
    int off = dir ? NW : 0;
    eh = 0; ec = 0; ea = 0; eb = 0; ed = 0; eo = 0;
    for (int i = NW - 1; i >= 0; i--) begin
      if (a_en[off+i] && addr >= a_base[off+i] && addr <= {32'h0, a_lim[off+i]}) begin
        eh = 1;
        ec = a_cfg[off+i];
        ea = ec ? 64'h0 : addr - a_base[off+i] + a_tgt[off+i];
        eb = ec ? a_tgt[off+i][31:24] : 8'h0;
        ed = ec ? a_tgt[off+i][23:16] : 8'h0;
        eo = ec ? addr[11:0] : 12'h0;
      end
    end
    @(negedge clk);
    lv = 1'b1; lin = dir; la = addr;
    @(negedge clk);
    lv = 1'b0;
    chk({tag, " valid"}, {63'h0, vo}, 64'h1);
    chk({tag, " hit"}, {63'h0, ho}, {63'h0, eh});
    chk({tag, " cfg"}, {63'h0, co}, {63'h0, ec});
    chk({tag, " addr"}, ao, ea);
    chk({tag, " bus/devfn/off"}, {36'h0, bo, dfo, oo}, {36'h0, eb, ed, eo});
  endtask

  task automatic prog(input int w, input logic [63:0] b, input logic [31:0] l,
                      input logic [63:0] t, input logic [31:0] kd, input logic [31:0] ct,
                      input bit do_ctrl);
    reg_wr(12'h900, (w >= NW ? 32'h8000_0000 : 32'h0) | 32'(w % NW));
    reg_wr(12'h90C, b[31:0]);  reg_wr(12'h910, b[63:32]);
    reg_wr(12'h914, l);
    reg_wr(12'h918, t[31:0]);  reg_wr(12'h91C, t[63:32]);
    reg_wr(12'h904, kd);
    if (do_ctrl) reg_wr(12'h908, ct);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    reg_rd_chk("R10 vsel reset", 12'h900);
    look("R8 idle-after-reset outbound miss R11", 1'b0, 64'h1234);
    reg_wr(12'h900, 32'h8000_0000);
    reg_rd_chk("R10 inbound0 ctrl", 12'h908);
    reg_rd_chk("R10 inbound0 limit", 12'h914);
    look("R10 inbound passthrough", 1'b1, 64'h1234_5678);
    look("R10 inbound top edge", 1'b1, 64'hFFFF_FFFF);
    look("R5 inbound above 4G miss", 1'b1, 64'h1_0000_0000);
    reg_wr(12'h900, 32'h0000_0005);
    reg_rd_chk("R10 outbound5 ctrl", 12'h908);
    reg_rd_chk("R10 outbound5 type", 12'h904);
    // R1 select readback
    reg_wr(12'h900, 32'h8000_0003);
    reg_rd_chk("R1 vsel readback", 12'h900);

    // R3 staged, R6 memory translation, R5 bounds
    prog(3, 64'h1000, 32'h1FFF, 64'h0000_ABCD_0000_0000, 32'h0, 32'h8000_0000, 1'b0);
    reg_rd_chk("R2 base lo", 12'h90C);
    reg_rd_chk("R2 tgt hi", 12'h91C);
    look("R3 staged only, no hit", 1'b0, 64'h1100);
    reg_wr(12'h908, 32'h8000_0000);
    look("R6 mem translate", 1'b0, 64'h1100);
    look("R5 low edge", 1'b0, 64'h1000);
    look("R5 high edge", 1'b0, 64'h1FFF);
    look("R5 below", 1'b0, 64'h0FFF);
    look("R5 above", 1'b0, 64'h2000);
    look("R11 inbound unaffected", 1'b1, 64'h1100);

    // R9 priority
    prog(1, 64'h1800, 32'h2FFF, 64'h0, 32'h0, 32'h8000_0000, 1'b1);
    look("R9 lower index wins", 1'b0, 64'h1900);
    look("R9 only high window", 1'b0, 64'h1200);

    // R7 switch to config, staged first
    reg_wr(12'h900, 32'h0000_0003);
    reg_wr(12'h904, 32'h1);
    reg_wr(12'h918, 32'h0508_0000);
    look("R3 type staged still mem", 1'b0, 64'h1234);
    reg_wr(12'h908, 32'h8000_0000);
    look("R7 config fields", 1'b0, 64'h1234);
    reg_wr(12'h904, 32'h0);
    reg_wr(12'h908, 32'h8000_0000);
    look("R7 back to mem", 1'b0, 64'h1234);
    // R4 disable
    reg_wr(12'h908, 32'h0);
    look("R4 disabled miss", 1'b0, 64'h1234);

    // R12 unmapped
    reg_rd_chk("R12 unmapped read", 12'h710);
    reg_wr(12'h710, 32'hFFFF_FFFF);
    reg_rd_chk("R12 vsel after stray write", 12'h900);
    reg_rd_chk("R12 type after stray write", 12'h904);
    look("R12 lookup after stray write", 1'b0, 64'h1900);

    // random mix
    for (int it = 0; it < 500; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) begin
        int w = $urandom_range(0, TOT - 1);
        logic [63:0] b, t;
        logic [31:0] l;
        b = {($urandom_range(0, 7) == 0) ? 32'h1 : 32'h0, $urandom_range(0, 32'h7FF0)};
        l = b[31:0] + 32'($urandom_range(0, 32'h1FFF)) - 32'h100;
        t = {32'($urandom_range(0, 3)), $urandom()};
        prog(w, b, l, t, ($urandom_range(0, 3) == 0) ? $urandom() : 32'h0,
             ($urandom_range(0, 3) == 0) ? 32'h0 : 32'h8000_0000 | $urandom_range(0, 255),
             $urandom_range(0, 4) != 0);
      end else if (op < 4) begin
        logic [11:0] a;
        a = 12'h900 + 12'(4 * $urandom_range(0, 8));
        reg_rd_chk("R2 random readback", a);
      end else begin
        logic [63:0] addr;
        addr = ($urandom_range(0, 15) == 0) ? {32'h1, $urandom()} : 64'($urandom_range(0, 32'h9FFF));
        look("R6/R7/R9 random lookup", 1'($urandom_range(0, 1)), addr);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule